// File: doc/BRIEF.md
# HDLC Receive Block Buffer

This block stores the bytes of received HDLC frames until a host processor collects them. An upstream deframer hands over one byte per cycle with a valid strobe and marks the last byte of each frame with an end-of-frame flag. The bytes go into a 128-byte ring that is split into two 64-byte halves. The host does not see individual bytes. It sees finished blocks.

A half is closed in one of two ways. If it fills to 64 bytes with no frame end, it raises a block-ready interrupt. If a frame ends inside it, it raises a frame-end interrupt and reports how many bytes remain in the frame's last block. The host reads the block through one read port that advances on each read strobe, then writes a command byte with the acknowledge bit set to release the half.

Only one interrupt is shown to the host at a time. The other half keeps filling in the background. A reset bit in the same command byte discards all buffered data and all pending interrupts.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After reset, `irq_blk`, `irq_end` and `overflow` are 0 and `end_count` is 0.
- R2: When 64 bytes of a frame have been accepted into a half with no frame end among them, `irq_blk` is 1 in the cycle after the clock edge that took the 64th byte. The 64 bytes are then presented on `rd_data` in arrival order, and each `rd_en` pulse advances to the next byte.
- R3: When a frame ends with N bytes in its last block (1 ≤ N ≤ 63), `irq_end` is 1 and `end_count` equals N in the cycle after the edge that took the final byte. Those N bytes are readable in order. `end_count` is 0 whenever `irq_end` is 0.
- R4: When a frame's length is a whole multiple of 64, its last block reports `irq_end` with `end_count` equal to 0, because the 6-bit count wraps.
- R5: A command write with bit 7 (acknowledge) set releases the block that is currently signalled. A command write without bit 7 or bit 6 set has no effect, and so does an acknowledge while no interrupt is pending.
- R6: At most one of `irq_blk` and `irq_end` is 1 at any time. A block that completes while another is pending stays hidden until that one is acknowledged, and then shows in the cycle after the acknowledge.
- R7: A byte that arrives while both halves hold unacknowledged blocks is dropped, leaving stored data intact, and sets `overflow`. `overflow` then stays 1 until a receiver reset.
- R8: A command write with bit 6 (receiver reset) set discards all buffered data and pending interrupts and clears `overflow`. It takes priority over an acknowledge bit in the same write.
- R9: A byte that closes a block and an acknowledge of the pending block in the same cycle both take effect. The newly closed block is signalled in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A received byte is present on `in_data` |
| in_data | input | 8 | Received byte |
| in_eof | input | 1 | The present byte is the last of its frame |
| rd_en | input | 1 | Host read strobe, advances to the next byte |
| rd_data | output | 8 | Byte at the host read position |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte: bit 7 acknowledge, bit 6 receiver reset |
| irq_blk | output | 1 | A full 64-byte block is ready |
| irq_end | output | 1 | A frame's last block is ready |
| end_count | output | 6 | Bytes in the last block of the frame, valid with `irq_end` |
| overflow | output | 1 | Sticky flag: an incoming byte was dropped |

## Verification
A byte that closes one half can reach the writer in the same cycle that the host acknowledges the other half. This means one half is being marked full while the other is released, and the read side moves between the two halves. The bench provokes this twice, once with a frame-end byte and once with a 64th byte, each driven in the same cycle as the acknowledge write. It then judges that the right interrupt kind and count appear exactly one cycle later and that the new block reads back intact.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int CMD_W       = 8;
  localparam int CMD_ACK_BIT = 7;
  localparam int CMD_RST_BIT = 6;

  typedef enum logic {
    BLK_FULL = 1'b0,
    BLK_TAIL = 1'b1
  } blk_kind_e;
endpackage

// File: rtl/hdlc_rx_mem.sv
module hdlc_rx_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/hdlc_rx_wr.sv
module hdlc_rx_wr
  import hdlc_rx_pkg::*;
#(
  parameter int HALF_DEPTH = 64,
  localparam int OFF_W     = $clog2(HALF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  input  logic             in_eof,
  input  logic [1:0]       half_busy,
  output logic             wr_en,
  output logic [OFF_W:0]   wr_addr,
  output logic             close,
  output logic             close_half,
  output blk_kind_e        close_kind,
  output logic [OFF_W-1:0] close_cnt,
  output logic             drop
);
  logic             wh;
  logic [OFF_W-1:0] wr_off;
  logic             last_slot;

  // Bytes held once the current byte lands; a full half wraps to 0.
  function automatic logic [OFF_W-1:0] tail_count(input logic [OFF_W-1:0] off);
    return off + 1'b1;
  endfunction

  assign last_slot  = (wr_off == OFF_W'(HALF_DEPTH - 1));
  assign wr_en      = in_valid & ~half_busy[wh];
  assign drop       = in_valid & half_busy[wh];
  assign wr_addr    = {wh, wr_off};
  assign close      = wr_en & (in_eof | last_slot);
  assign close_half = wh;
  assign close_kind = in_eof ? BLK_TAIL : BLK_FULL;
  assign close_cnt  = tail_count(wr_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wh     <= 1'b0;
      wr_off <= '0;
    end else if (flush) begin
      wh     <= 1'b0;
      wr_off <= '0;
    end else if (close) begin
      wh     <= ~wh;
      wr_off <= '0;
    end else if (wr_en) begin
      wr_off <= wr_off + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rx_blk.sv
module hdlc_rx_blk
  import hdlc_rx_pkg::*;
#(
  parameter int HALF_DEPTH = 64,
  localparam int OFF_W     = $clog2(HALF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ack_req,
  input  logic             rd_req,
  input  logic             close,
  input  logic             close_half,
  input  blk_kind_e        close_kind,
  input  logic [OFF_W-1:0] close_cnt,
  output logic [1:0]       busy,
  output logic [OFF_W:0]   rd_addr,
  output logic             irq_thresh,
  output logic             irq_tail,
  output logic [OFF_W-1:0] tail_cnt,
  output logic             ack_fire
);
  blk_kind_e        kind [2];
  logic [OFF_W-1:0] cnt  [2];
  logic             rh;
  logic [OFF_W-1:0] rd_off;

  assign ack_fire   = ack_req & busy[rh];
  assign irq_thresh = busy[rh] & (kind[rh] == BLK_FULL);
  assign irq_tail   = busy[rh] & (kind[rh] == BLK_TAIL);
  assign tail_cnt   = irq_tail ? cnt[rh] : '0;
  assign rd_addr    = {rh, rd_off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= '0;
      rh     <= 1'b0;
      rd_off <= '0;
      for (int h = 0; h < 2; h++) begin
        kind[h] <= BLK_FULL;
        cnt[h]  <= '0;
      end
    end else if (flush) begin
      busy   <= '0;
      rh     <= 1'b0;
      rd_off <= '0;
    end else begin
      if (ack_fire) begin
        busy[rh] <= 1'b0;
        rh       <= ~rh;
        rd_off   <= '0;
      end else if (rd_req && busy[rh]) begin
        rd_off <= rd_off + 1'b1;
      end
      // A closing half is never the one being released: the writer stalls on a busy half.
      if (close) begin
        busy[close_half] <= 1'b1;
        kind[close_half] <= close_kind;
        cnt[close_half]  <= close_cnt;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hdlc_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HALF_DEPTH = 64,
  localparam int OFF_W     = $clog2(HALF_DEPTH),
  localparam int DEPTH     = 2 * HALF_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_eof,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              irq_blk,
  output logic              irq_end,
  output logic [OFF_W-1:0]  end_count,
  output logic              overflow
);
  logic             flush;
  logic             ack_req;
  logic             ack_fire;
  logic             wr_en;
  logic [OFF_W:0]   wr_addr;
  logic [OFF_W:0]   rd_addr;
  logic             blk_close;
  logic             close_half;
  blk_kind_e        close_kind;
  logic [OFF_W-1:0] close_cnt;
  logic             drop;
  logic [1:0]       half_busy;

  assign flush   = cmd_we & cmd_data[CMD_RST_BIT];
  assign ack_req = cmd_we & cmd_data[CMD_ACK_BIT] & ~flush;

  hdlc_rx_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (in_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  hdlc_rx_wr #(.HALF_DEPTH(HALF_DEPTH)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .in_valid   (in_valid),
    .in_eof     (in_eof),
    .half_busy  (half_busy),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .close      (blk_close),
    .close_half (close_half),
    .close_kind (close_kind),
    .close_cnt  (close_cnt),
    .drop       (drop)
  );

  hdlc_rx_blk #(.HALF_DEPTH(HALF_DEPTH)) u_blk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .ack_req    (ack_req),
    .rd_req     (rd_en),
    .close      (blk_close),
    .close_half (close_half),
    .close_kind (close_kind),
    .close_cnt  (close_cnt),
    .busy       (half_busy),
    .rd_addr    (rd_addr),
    .irq_thresh (irq_blk),
    .irq_tail   (irq_end),
    .tail_cnt   (end_count),
    .ack_fire   (ack_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     overflow <= 1'b0;
    else if (flush) overflow <= 1'b0;
    else if (drop)  overflow <= 1'b1;
  end
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk
  import hdlc_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic [CMD_W-1:0] cmd_data,
  input logic             flush,
  input logic             ack_fire,
  input logic             blk_close,
  input logic             drop,
  input logic             irq_blk,
  input logic             irq_end,
  input logic [CNT_W-1:0] end_count,
  input logic             overflow
);
  p_one_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_blk, irq_end}));

  p_irq_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_blk || irq_end) && !ack_fire && !flush) |=> $stable({irq_blk, irq_end, end_count}));

  p_count_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_end |-> (end_count == '0));

  p_drop_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !flush) |=> overflow);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush) |=> overflow);

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!irq_blk && !irq_end && !overflow));

  p_zero_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !cmd_data[CMD_ACK_BIT] && !cmd_data[CMD_RST_BIT] && !blk_close && !drop)
      |=> $stable({irq_blk, irq_end, end_count, overflow}));
endmodule

bind hdlc_rx_fifo hdlc_rx_chk #(.CNT_W(OFF_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_we    (cmd_we),
  .cmd_data  (cmd_data),
  .flush     (flush),
  .ack_fire  (ack_fire),
  .blk_close (blk_close),
  .drop      (drop),
  .irq_blk   (irq_blk),
  .irq_end   (irq_end),
  .end_count (end_count),
  .overflow  (overflow)
);

// File: tb/test_hdlc_rx_fifo.sv
module test_hdlc_rx_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_eof = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_data = '0;
  logic       irq_blk;
  logic       irq_end;
  logic [5:0] end_count;
  logic       overflow;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  hdlc_rx_fifo i_hdlc_rx_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof),
    .rd_en(rd_en), .rd_data(rd_data), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .irq_blk(irq_blk), .irq_end(irq_end), .end_count(end_count), .overflow(overflow)
  );

  function automatic logic [7:0] pat(int seed, int idx);
    return 8'((seed * 37 + idx * 5 + 3) & 255);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int seed, int first, int n, bit eof_last);
    for (int i = first; i < first + n; i++) begin
      in_valid = 1'b1;
      in_data  = pat(seed, i);
      in_eof   = eof_last && (i == first + n - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_eof   = 1'b0;
  endtask

  task automatic command(logic [7:0] v);
    cmd_we = 1'b1;
    cmd_data = v;
    @(negedge clk);
    cmd_we = 1'b0;
    cmd_data = '0;
  endtask

  task automatic read_blk(string req, int seed, int n);
    int errs = 0;
    for (int i = 0; i < n; i++) begin
      if (rd_data !== pat(seed, i)) begin
        if (errs == 0) chk(req, rd_data, pat(seed, i));
        errs++;
      end
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
    if (errs == 0) chk(req, 0, 0);
  endtask

  task automatic irqs(string req, int blk, int fin, int cnt);
    chk(req, irq_blk, blk);
    chk(req, irq_end, fin);
    chk(req, end_count, cnt);
  endtask

  task automatic t_reset;
    irqs("R1", 0, 0, 0);
    chk("R1", overflow, 0);
  endtask

  task automatic t_threshold;
    send(1, 0, 64, 1'b0);
    irqs("R2", 1, 0, 0);
    read_blk("R2", 1, 64);
    command(8'h80);
    irqs("R5", 0, 0, 0);
  endtask

  task automatic t_frame_end;
    send(2, 0, 10, 1'b1);
    irqs("R3", 0, 1, 10);
    read_blk("R3", 2, 10);
    command(8'h80);
  endtask

  task automatic t_exact_multiple;
    send(3, 0, 64, 1'b0);
    send(4, 0, 64, 1'b1);
    irqs("R6", 1, 0, 0);
    read_blk("R2", 3, 64);
    command(8'h80);
    irqs("R4", 0, 1, 0);
    read_blk("R4", 4, 64);
    command(8'h80);
    irqs("R4", 0, 0, 0);
  endtask

  task automatic t_cmd_no_effect;
    command(8'h80);
    irqs("R5", 0, 0, 0);
    send(5, 0, 5, 1'b1);
    command(8'h3F);
    irqs("R5", 0, 1, 5);
    read_blk("R5", 5, 5);
    command(8'h80);
    send(6, 0, 3, 1'b1);
    irqs("R5", 0, 1, 3);
    read_blk("R5", 6, 3);
    command(8'h80);
  endtask

  task automatic t_overflow;
    send(7, 0, 64, 1'b0);
    send(8, 0, 64, 1'b0);
    chk("R7", overflow, 0);
    send(9, 0, 3, 1'b1);
    chk("R7", overflow, 1);
    irqs("R6", 1, 0, 0);
    read_blk("R7", 7, 64);
    command(8'h80);
    irqs("R7", 1, 0, 0);
    read_blk("R7", 8, 64);
    command(8'h80);
    irqs("R7", 0, 0, 0);
    chk("R7", overflow, 1);
    send(10, 0, 10, 1'b1);
    command(8'hC0);
    irqs("R8", 0, 0, 0);
    chk("R8", overflow, 0);
    send(11, 0, 4, 1'b1);
    irqs("R8", 0, 1, 4);
    read_blk("R8", 11, 4);
    command(8'h80);
  endtask

  task automatic t_same_cycle;
    send(12, 0, 64, 1'b0);
    send(13, 0, 19, 1'b0);
    read_blk("R9", 12, 64);
    cmd_we = 1'b1;
    cmd_data = 8'h80;
    send(13, 19, 1, 1'b1);
    cmd_we = 1'b0;
    cmd_data = '0;
    irqs("R9", 0, 1, 20);
    read_blk("R9", 13, 20);
    command(8'h80);
    send(14, 0, 64, 1'b0);
    send(15, 0, 63, 1'b0);
    read_blk("R9", 14, 64);
    cmd_we = 1'b1;
    cmd_data = 8'h80;
    send(15, 63, 1, 1'b0);
    cmd_we = 1'b0;
    cmd_data = '0;
    irqs("R9", 1, 0, 0);
    read_blk("R9", 15, 64);
    command(8'h80);
    irqs("R9", 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_frame_end();
    t_exact_multiple();
    t_cmd_no_effect();
    t_overflow();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule